// File: doc/BRIEF.md
# Quad Wiper Register Controller

This block is the register core behind a bank of four 256-position digital potentiometers. Each potentiometer has one 8-bit wiper register and four 8-bit retained data registers. The wiper register picks the single tap that connects to the wiper, and the block drives that choice as a one-hot 256-bit tap-select slice per potentiometer. The retained registers stand in for non-volatile storage. They are ordinary flops, and every write to them starts a fixed busy interval.

Commands arrive on a parallel port that a serial front end would drive after decoding. A command carries a potentiometer index, a register index, a 3-bit opcode and a data byte, and it is sampled on any clock edge where `cmdValid` is high. The opcodes cover:

- reading and writing a wiper register;
- reading and writing a retained register;
- storing a wiper value into one of its own potentiometer's retained registers;
- recalling a retained value into the wiper register;
- stepping the wiper up or down by one tap.

An active-low write-protect input refuses retained-register writes. Wiper changes still take effect while it is low.

Top module: `wiper_bank_core`

## Requirements
- R1: After reset, every wiper register and every retained register holds 0x80, `busy`, `rdValid`, `cmdError` and `wpViolation` are low, and each tap-select slice selects tap 128.
- R2: Each potentiometer's 256-bit tap-select slice (bits p*256 to p*256+255) has exactly one bit set, at the position equal to that wiper register's value.
- R3: Opcode 1 (write wiper) loads `cmdData` into the addressed wiper register by the next cycle, whether `wpN` is high or low.
- R4: Opcode 0 (read wiper) and opcode 2 (read retained register `cmdReg`) raise `rdValid` for one cycle on the cycle after the command, with `rdData` holding the addressed value.
- R5: With `wpN` high, opcode 3 (write retained) loads `cmdData` into retained register `cmdReg` of potentiometer `cmdPot` and holds `busy` high for exactly 8 cycles, beginning the cycle after the command.
- R6: With `wpN` low, opcode 3 and opcode 4 leave the retained register unchanged, do not raise `busy`, and pulse `wpViolation` for one cycle on the cycle after the command.
- R7: Opcode 4 (store) copies the wiper register into retained register `cmdReg` of the same potentiometer and starts the same 8-cycle busy interval. Opcode 5 (recall) copies that retained register into the wiper register, and this is allowed while `wpN` is low.
- R8: Opcode 6 raises the addressed wiper register by one and opcode 7 lowers it by one. Each saturates at the end of the range: 255 stays 255 and 0 stays 0.
- R9: A command presented while `busy` is high has no effect on any register, produces no `rdValid`, and pulses `cmdError` for one cycle on the next cycle.
- R10: A command addressed to one potentiometer leaves the registers of the other potentiometers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdPot | input | 2 | Potentiometer index |
| cmdReg | input | 2 | Retained register index within the potentiometer |
| cmdOp | input | 3 | Opcode (0 read wiper, 1 write wiper, 2 read retained, 3 write retained, 4 store, 5 recall, 6 step up, 7 step down) |
| cmdData | input | 8 | Write data |
| wpN | input | 1 | Write protect, active low; high allows retained writes |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | 8 | Read data |
| busy | output | 1 | Retained write in progress; commands are rejected |
| cmdError | output | 1 | Pulse: command rejected because the block was busy |
| wpViolation | output | 1 | Pulse: retained write refused by write protect |
| tapSel | output | 1024 | One-hot tap select, 256 bits per potentiometer |

## Verification
The hardest cases to reach are those where a command arrives inside the busy window. The bench issues a retained write and, on the very next cycle, a wiper write and then a read. It checks that both are rejected, that the wiper keeps its old value and that no read data appears. The busy length is measured by counting cycles at the ports. Saturation is reached by first writing 0xFE or 0x01 into a wiper and then stepping twice. Recall under write protect follows a store made while protection was off, which proves that the retained path is refused while the wiper path stays open.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [2:0] {
    OP_RD_WIPER = 3'd0,
    OP_WR_WIPER = 3'd1,
    OP_RD_DATA  = 3'd2,
    OP_WR_DATA  = 3'd3,
    OP_STORE    = 3'd4,
    OP_RECALL   = 3'd5,
    OP_STEP_UP  = 3'd6,
    OP_STEP_DN  = 3'd7
  } op_e;

  typedef struct packed {
    logic readWiper;
    logic readData;
    logic writeWiper;
    logic writeData;
    logic store;
    logic recall;
    logic stepUp;
    logic stepDown;
  } strobe_t;

endpackage

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int BUSY_CYCLES = 8,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       wpN,
  output strobe_t    stb,
  output logic       busy,
  output logic       cmdError,
  output logic       wpViolation
);

  localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] busyCnt;
  logic          accept;
  logic          refused;
  logic          startBusy;

  assign busy   = (busyCnt != '0);
  assign accept = cmdValid && !busy;

  always_comb begin
    stb     = '0;
    refused = 1'b0;
    if (accept) begin
      case (op_e'(cmdOp))
        OP_RD_WIPER: stb.readWiper  = 1'b1;
        OP_WR_WIPER: stb.writeWiper = 1'b1;
        OP_RD_DATA:  stb.readData   = 1'b1;
        OP_WR_DATA: begin
          stb.writeData = wpN;
          refused       = !wpN;
        end
        OP_STORE: begin
          stb.store = wpN;
          refused   = !wpN;
        end
        OP_RECALL:   stb.recall   = 1'b1;
        OP_STEP_UP:  stb.stepUp   = 1'b1;
        OP_STEP_DN:  stb.stepDown = 1'b1;
        default:     stb          = '0;
      endcase
    end
  end

  assign startBusy = stb.writeData || stb.store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyCnt     <= '0;
      cmdError    <= 1'b0;
      wpViolation <= 1'b0;
    end else begin
      if (startBusy)   busyCnt <= BUSY_LOAD;
      else if (busy)   busyCnt <= busyCnt - 1'b1;
      cmdError    <= cmdValid && busy;
      wpViolation <= refused;
    end
  end

endmodule

// File: rtl/wbc_datapath.sv
module wbc_datapath
  import wbc_pkg::*;
#(
  parameter int NPOT  = 4,
  parameter int NREG  = 4,
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = 8'h80,
  localparam int PW   = $clog2(NPOT),
  localparam int RW   = $clog2(NREG),
  localparam int TAPS = 1 << WIDTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              stb,
  input  logic [PW-1:0]        pot,
  input  logic [RW-1:0]        regIdx,
  input  logic [WIDTH-1:0]     wrVal,
  output logic                 rdValid,
  output logic [WIDTH-1:0]     rdData,
  output logic [NPOT*TAPS-1:0] tapSel
);

  localparam logic [WIDTH-1:0] MAXV = '1;
  localparam logic [TAPS-1:0]  ONE  = TAPS'(1);

  logic [WIDTH-1:0] wiper   [NPOT];
  logic [WIDTH-1:0] dataReg [NPOT][NREG];
  logic [WIDTH-1:0] curWiper;
  logic [WIDTH-1:0] curData;

  assign curWiper = wiper[pot];
  assign curData  = dataReg[pot][regIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      for (int p = 0; p < NPOT; p++) begin
        wiper[p] <= RESET_VAL;
        for (int r = 0; r < NREG; r++) dataReg[p][r] <= RESET_VAL;
      end
    end else begin
      rdValid <= stb.readWiper || stb.readData;
      if (stb.readWiper) rdData <= curWiper;
      if (stb.readData)  rdData <= curData;
      if (stb.writeWiper) wiper[pot] <= wrVal;
      if (stb.recall)     wiper[pot] <= curData;
      if (stb.stepUp && curWiper != MAXV)   wiper[pot] <= curWiper + 1'b1;
      if (stb.stepDown && curWiper != '0)   wiper[pot] <= curWiper - 1'b1;
      if (stb.writeData) dataReg[pot][regIdx] <= wrVal;
      if (stb.store)     dataReg[pot][regIdx] <= curWiper;
    end
  end

  for (genvar p = 0; p < NPOT; p++) begin : g_tap
    assign tapSel[p*TAPS +: TAPS] = ONE << wiper[p];
  end

endmodule

// File: rtl/wiper_bank_core.sv
module wiper_bank_core
  import wbc_pkg::*;
#(
  parameter int NPOT        = 4,
  parameter int NREG        = 4,
  parameter int WIDTH       = 8,
  parameter int BUSY_CYCLES = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = 8'h80,
  localparam int PW   = $clog2(NPOT),
  localparam int RW   = $clog2(NREG),
  localparam int TAPS = 1 << WIDTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdValid,
  input  logic [PW-1:0]        cmdPot,
  input  logic [RW-1:0]        cmdReg,
  input  logic [2:0]           cmdOp,
  input  logic [WIDTH-1:0]     cmdData,
  input  logic                 wpN,
  output logic                 rdValid,
  output logic [WIDTH-1:0]     rdData,
  output logic                 busy,
  output logic                 cmdError,
  output logic                 wpViolation,
  output logic [NPOT*TAPS-1:0] tapSel
);

  strobe_t stb;

  wbc_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp), .wpN(wpN),
    .stb(stb), .busy(busy), .cmdError(cmdError), .wpViolation(wpViolation)
  );

  wbc_datapath #(.NPOT(NPOT), .NREG(NREG), .WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .pot(cmdPot), .regIdx(cmdReg),
    .wrVal(cmdData), .rdValid(rdValid), .rdData(rdData), .tapSel(tapSel)
  );

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int NPOT        = 4,
  parameter int WIDTH       = 8,
  parameter int BUSY_CYCLES = 8,
  localparam int TAPS = 1 << WIDTH,
  localparam int BW   = $clog2(BUSY_CYCLES + 2) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmdValid,
  input logic [2:0]           cmdOp,
  input logic                 wpN,
  input logic                 rdValid,
  input logic                 busy,
  input logic                 cmdError,
  input logic                 wpViolation,
  input logic [NPOT*TAPS-1:0] tapSel
);

  logic [BW-1:0] busyRun;
  logic          isRead;
  logic          isRetWr;

  assign isRead  = (cmdOp == 3'd0) || (cmdOp == 3'd2);
  assign isRetWr = (cmdOp == 3'd3) || (cmdOp == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  for (genvar p = 0; p < NPOT; p++) begin : g_onehot
    assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tapSel[p*TAPS +: TAPS]) == 1);
  end

  assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !busy && isRead |=> rdValid);

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !busy && wpN && isRetWr |=> busy);

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busyRun <= BW'(BUSY_CYCLES));

  assert_wp_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !busy && !wpN && isRetWr |=> wpViolation && !busy);

  assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && busy |=> cmdError && !rdValid && !wpViolation);

endmodule

bind wiper_bank_core wbc_checker #(.NPOT(NPOT), .WIDTH(WIDTH), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp), .wpN(wpN),
  .rdValid(rdValid), .busy(busy), .cmdError(cmdError), .wpViolation(wpViolation),
  .tapSel(tapSel)
);

// File: tb/wiper_bank_core_bench.sv
module wiper_bank_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdPot = '0;
  logic [1:0]  cmdReg = '0;
  logic [2:0]  cmdOp = '0;
  logic [7:0]  cmdData = '0;
  logic        wpN = 1'b1;
  logic        rdValid;
  logic [7:0]  rdData;
  logic        busy;
  logic        cmdError;
  logic        wpViolation;
  logic [1023:0] tapSel;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  wiper_bank_core u_wiper_bank_core (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdPot(cmdPot), .cmdReg(cmdReg),
    .cmdOp(cmdOp), .cmdData(cmdData), .wpN(wpN), .rdValid(rdValid), .rdData(rdData),
    .busy(busy), .cmdError(cmdError), .wpViolation(wpViolation), .tapSel(tapSel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  function automatic int tapPos(input int p);
    int pos = -1;
    int cnt = 0;
    for (int i = 0; i < 256; i++) if (tapSel[p*256 + i]) begin pos = i; cnt++; end
    return (cnt == 1) ? pos : -1;
  endfunction

  // Presents one command for one clock edge; returns at the following negedge.
  task automatic issue(input int pot, input int rg, input int op, input int dat);
    cmdPot = 2'(pot); cmdReg = 2'(rg); cmdOp = 3'(op); cmdData = 8'(dat);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic readReg(input int pot, input int rg, input bit isData,
                         input string req, input int exp);
    issue(pot, rg, isData ? 2 : 0, 0);
    check(rdValid == 1'b1, req, int'(rdValid), 1);
    check(rdData == 8'(exp), req, int'(rdData), exp);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check(busy == 0 && cmdError == 0 && wpViolation == 0 && rdValid == 0, "R1",
          int'({busy, cmdError, wpViolation, rdValid}), 0);
    for (int p = 0; p < 4; p++) check(tapPos(p) == 128, "R1", tapPos(p), 128);
    readReg(0, 0, 0, "R1", 8'h80);
    readReg(3, 0, 0, "R1", 8'h80);
    readReg(0, 3, 1, "R1", 8'h80);
    readReg(2, 1, 1, "R1", 8'h80);
    @(negedge clk);
    check(rdValid == 0, "R4", int'(rdValid), 0);
  endtask

  task automatic t_write_wiper();
    wpN = 1'b0;
    issue(1, 0, 1, 8'h3C);
    check(tapPos(1) == 8'h3C, "R3", tapPos(1), 8'h3C);
    check(tapPos(1) == 8'h3C, "R2", tapPos(1), 8'h3C);
    readReg(1, 0, 0, "R3", 8'h3C);
    wpN = 1'b1;
    issue(1, 0, 1, 8'hFF);
    check(tapPos(1) == 255, "R2", tapPos(1), 255);
    check(tapPos(0) == 128, "R10", tapPos(0), 128);
  endtask

  task automatic t_data_write();
    int n = 0;
    wpN = 1'b1;
    issue(2, 1, 3, 8'hA5);
    while (busy) begin n++; @(negedge clk); end
    check(n == 8, "R5", n, 8);
    readReg(2, 1, 1, "R5", 8'hA5);
    readReg(2, 0, 1, "R10", 8'h80);
    readReg(1, 1, 1, "R10", 8'h80);
  endtask

  task automatic t_busy_reject();
    wpN = 1'b1;
    issue(0, 0, 3, 8'h11);
    issue(0, 0, 1, 8'h22);
    check(cmdError == 1, "R9", int'(cmdError), 1);
    issue(0, 0, 0, 0);
    check(cmdError == 1 && rdValid == 0, "R9", int'({cmdError, rdValid}), 2);
    @(negedge clk);
    check(cmdError == 0, "R9", int'(cmdError), 0);
    waitIdle();
    check(tapPos(0) == 128, "R9", tapPos(0), 128);
    readReg(0, 0, 0, "R9", 8'h80);
    readReg(0, 0, 1, "R5", 8'h11);
  endtask

  task automatic t_write_protect();
    wpN = 1'b0;
    issue(3, 2, 3, 8'h5A);
    check(wpViolation == 1 && busy == 0, "R6", int'({wpViolation, busy}), 2);
    @(negedge clk);
    check(wpViolation == 0, "R6", int'(wpViolation), 0);
    readReg(3, 2, 1, "R6", 8'h80);
    issue(3, 2, 1, 8'h07);
    issue(3, 2, 4, 0);
    check(wpViolation == 1 && busy == 0, "R6", int'({wpViolation, busy}), 2);
    readReg(3, 2, 1, "R6", 8'h80);
    wpN = 1'b1;
  endtask

  task automatic t_store_recall();
    wpN = 1'b1;
    issue(2, 0, 1, 8'h40);
    issue(2, 3, 4, 0);
    check(busy == 1, "R7", int'(busy), 1);
    waitIdle();
    readReg(2, 3, 1, "R7", 8'h40);
    readReg(1, 3, 1, "R10", 8'h80);
    issue(2, 0, 1, 8'h00);
    wpN = 1'b0;
    issue(2, 3, 5, 0);
    check(tapPos(2) == 8'h40 && busy == 0, "R7", tapPos(2), 8'h40);
    readReg(2, 0, 0, "R7", 8'h40);
    wpN = 1'b1;
  endtask

  task automatic t_step();
    issue(3, 0, 1, 8'hFE);
    issue(3, 0, 6, 0);
    check(tapPos(3) == 255, "R8", tapPos(3), 255);
    issue(3, 0, 6, 0);
    check(tapPos(3) == 255, "R8", tapPos(3), 255);
    readReg(3, 0, 0, "R8", 8'hFF);
    issue(3, 0, 1, 8'h01);
    issue(3, 0, 7, 0);
    check(tapPos(3) == 0, "R8", tapPos(3), 0);
    issue(3, 0, 7, 0);
    check(tapPos(3) == 0, "R8", tapPos(3), 0);
    issue(3, 0, 6, 0);
    check(tapPos(3) == 1, "R8", tapPos(3), 1);
    check(tapPos(2) == 8'h40, "R10", tapPos(2), 8'h40);
  endtask

  initial begin
    #1000000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_wiper();
    t_data_write();
    t_busy_reject();
    t_write_protect();
    t_store_recall();
    t_step();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule